// File: doc/BRIEF.md
# Effective Write Stress Estimator

This block sits beside the write path of a resistive crossbar memory controller and prices every write by the wear it causes rather than by a flat count of one. The mat's rows fall into eight row-address groups of 64 consecutive rows. For each group the block keeps two pessimistic bitline counts. One counts conductive (low-resistance) cells and the other counts resistive (high-resistance) cells. A profiling pass loads these counts, and every write to the group then raises both by one so that the estimate stays pessimistic.

For each write the block quantises the two counts to 3-bit ratios. The conductive ratio selects a RESET latency code from a per-group table. That latency fixes a base charge, which is the ceiling of the squared ratio between the longest latency and this one. The sum of the two ratios selects an exponential over-RESET scale, and the base charge is multiplied by it. The product is the increment the controller adds to the lifetime counter of the written chunk. All tables are computed at elaboration, so the block contains no runtime divider and no exponent unit.

Top module: `stress_est`

## Requirements
- R1: The group of a write is the top three bits of the 9-bit row address (row[8:6]), so rows 0..63 are group 0 and rows 448..511 are group 7.
- R2: A profile load writes both counts of the addressed group, clamping each value to 64. When a load and a write hit the same group in the same cycle, the loaded values are stored. The write is still charged from the old counts plus one.
- R3: Each write raises both counts of its group by one and never above 64. Other groups are left unchanged.
- R4: A write is charged from its group's counts after the increment. Each count maps to the ratio min(count/8, 7), using integer division.
- R5: The latency code is 16 + qL*(4 + 2*(7 - g)), where qL is the conductive ratio and g is the group. It ranges from 16 up to 142, and 142 occurs at group 0 with qL = 7.
- R6: The base charge is ceil(142*142 / (t*t)) for latency code t. Group 0 at qL = 7 therefore costs exactly 1.
- R7: With k = max(qL + qH - 7, 0), the scale in sixteenths is 16*2^k. The increment is ceil(base*scale/16).
- R8: The increment saturates at 255.
- R9: out_valid is high for one cycle exactly two cycles after each cycle with wr_req high. Back-to-back writes give back-to-back results.
- R10: Reset clears all counts and drives out_valid, out_lat and out_ew to 0. out_lat and out_ew keep their last values while out_valid is low.
- R11: A profile load on its own produces no output strobe and leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Write request strobe |
| wr_row | input | 9 | Row address of the write |
| prof_load | input | 1 | Load profiled counts for one group |
| prof_grp | input | 3 | Group written by the profile load |
| prof_lrs | input | 7 | Profiled conductive-cell count |
| prof_hrs | input | 7 | Profiled resistive-cell count |
| out_valid | output | 1 | Result strobe |
| out_lat | output | 8 | RESET latency code of the write |
| out_ew | output | 8 | Effective-write increment |

## Verification
The bench aims at the normalisation point, where group 0 at full conductive ratio must cost exactly 1. A latency table built the wrong way round would instead charge far more there. It drives a profile load and a write into the same group in one cycle; a design that let the write win would leave counts one higher, and the next write's latency and charge would drift. It loads values above the bitline height, and it drives ratio pairs whose sum crosses 7 so that the scale index is exercised. An off-by-one in that index shows up as a charge that is doubled or halved. It also pushes charges past 255, where a missing clamp would wrap to a small value.

// File: rtl/se_pkg.sv
package se_pkg;

   localparam int unsigned SCALE_FRAC = 4;

   function automatic int unsigned lat_of(int unsigned g, int unsigned q, int unsigned ngrp,
                                          int unsigned tmin, int unsigned qstep, int unsigned gstep);
      return tmin + q * (qstep + (ngrp - 1 - g) * gstep);
   endfunction

   function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
      return (a + b - 1) / b;
   endfunction

   // Over-RESET scale in sixteenths, grown by growth/16 per step of k.
   function automatic int unsigned scale_of(int unsigned k, int unsigned growth);
      int unsigned s;
      s = 1 << SCALE_FRAC;
      for (int unsigned i = 0; i < k; i++) s = (s * growth + (1 << (SCALE_FRAC - 1))) >> SCALE_FRAC;
      return s;
   endfunction

endpackage

// File: rtl/se_group_cnt.sv
module se_group_cnt #(
   parameter int GRP_W     = 3,
   parameter int CNT_W     = 7,
   parameter int BL_HEIGHT = 64,
   localparam int NGRP     = 1 << GRP_W
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [GRP_W-1:0]               wr_grp,
   input  logic                           ld_en,
   input  logic [GRP_W-1:0]               ld_grp,
   input  logic [CNT_W-1:0]               ld_lrs,
   input  logic [CNT_W-1:0]               ld_hrs,
   output logic [CNT_W-1:0]               inc_lrs,
   output logic [CNT_W-1:0]               inc_hrs,
   output logic [NGRP-1:0][CNT_W-1:0]     cnt_lrs,
   output logic [NGRP-1:0][CNT_W-1:0]     cnt_hrs
);

   localparam logic [CNT_W-1:0] CAP = CNT_W'(BL_HEIGHT);

   logic [CNT_W-1:0] lrs_q [NGRP];
   logic [CNT_W-1:0] hrs_q [NGRP];
   logic [CNT_W-1:0] ld_lrs_c, ld_hrs_c;

   function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
      return (v >= CAP) ? CAP : v + 1'b1;
   endfunction

   always_comb begin
      inc_lrs  = bump(lrs_q[wr_grp]);
      inc_hrs  = bump(hrs_q[wr_grp]);
      ld_lrs_c = (ld_lrs > CAP) ? CAP : ld_lrs;
      ld_hrs_c = (ld_hrs > CAP) ? CAP : ld_hrs;
      for (int i = 0; i < NGRP; i++) begin
         cnt_lrs[i] = lrs_q[i];
         cnt_hrs[i] = hrs_q[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NGRP; i++) begin
            lrs_q[i] <= '0;
            hrs_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < NGRP; i++) begin
            if (ld_en && ld_grp == GRP_W'(i)) begin
               lrs_q[i] <= ld_lrs_c;
               hrs_q[i] <= ld_hrs_c;
            end else if (wr_en && wr_grp == GRP_W'(i)) begin
               lrs_q[i] <= inc_lrs;
               hrs_q[i] <= inc_hrs;
            end
         end
      end
   end

endmodule

// File: rtl/se_quant.sv
module se_quant #(
   parameter int CNT_W = 7,
   parameter int Q_W   = 3,
   parameter int QSH   = 3
) (
   input  logic [CNT_W-1:0] cnt,
   output logic [Q_W-1:0]   q
);

   localparam logic [CNT_W-1:0] QMAX = CNT_W'((1 << Q_W) - 1);

   logic [CNT_W-1:0] shifted;

   always_comb begin
      shifted = cnt >> QSH;
      q       = (shifted > QMAX) ? QMAX[Q_W-1:0] : shifted[Q_W-1:0];
   end

endmodule

// File: rtl/se_charge.sv
module se_charge #(
   parameter int GRP_W     = 3,
   parameter int Q_W       = 3,
   parameter int LAT_W     = 8,
   parameter int EW_W      = 8,
   parameter int T_MIN     = 16,
   parameter int Q_STEP    = 4,
   parameter int G_STEP    = 2,
   parameter int GROWTH_Q4 = 32
) (
   input  logic [GRP_W-1:0] grp,
   input  logic [Q_W-1:0]   ql,
   input  logic [Q_W-1:0]   qh,
   output logic [LAT_W-1:0] lat,
   output logic [EW_W-1:0]  ew
);

   localparam int NGRP   = 1 << GRP_W;
   localparam int NQ     = 1 << Q_W;
   localparam int BASE_W = 16;
   localparam int SCL_W  = 32;
   localparam int PRD_W  = BASE_W + SCL_W;
   localparam int unsigned T_LONG = se_pkg::lat_of(0, NQ - 1, NGRP, T_MIN, Q_STEP, G_STEP);
   localparam logic [PRD_W-1:0] EW_MAX = PRD_W'((1 << EW_W) - 1);
   localparam logic [PRD_W-1:0] RND    = PRD_W'((1 << se_pkg::SCALE_FRAC) - 1);

   logic [LAT_W-1:0]  lat_rom   [NGRP][NQ];
   logic [BASE_W-1:0] base_rom  [NGRP][NQ];
   logic [SCL_W-1:0]  scale_rom [NQ];

   for (genvar g = 0; g < NGRP; g++) begin : g_row
      for (genvar q = 0; q < NQ; q++) begin : g_col
         localparam int unsigned T = se_pkg::lat_of(g, q, NGRP, T_MIN, Q_STEP, G_STEP);
         assign lat_rom[g][q]  = LAT_W'(T);
         assign base_rom[g][q] = BASE_W'(se_pkg::ceil_div(T_LONG * T_LONG, T * T));
      end
   end

   for (genvar k = 0; k < NQ; k++) begin : g_scale
      assign scale_rom[k] = SCL_W'(se_pkg::scale_of(k, GROWTH_Q4));
   end

   logic [Q_W:0]       qsum;
   logic [Q_W-1:0]     kidx;
   logic [PRD_W-1:0]   prod;
   logic [PRD_W-1:0]   raw;

   always_comb begin
      qsum = {1'b0, ql} + {1'b0, qh};
      kidx = (qsum > (Q_W+1)'(NQ - 1)) ? Q_W'(qsum - (Q_W+1)'(NQ - 1)) : '0;
      prod = PRD_W'(base_rom[grp][ql]) * PRD_W'(scale_rom[kidx]);
      raw  = (prod + RND) >> se_pkg::SCALE_FRAC;
      lat  = lat_rom[grp][ql];
      ew   = (raw > EW_MAX) ? EW_MAX[EW_W-1:0] : raw[EW_W-1:0];
   end

endmodule

// File: rtl/stress_est.sv
module stress_est #(
   parameter int ROW_W     = 9,
   parameter int GRP_W     = 3,
   parameter int BL_HEIGHT = 64,
   parameter int Q_W       = 3,
   parameter int LAT_W     = 8,
   parameter int EW_W      = 8,
   parameter int T_MIN     = 16,
   parameter int Q_STEP    = 4,
   parameter int G_STEP    = 2,
   parameter int GROWTH_Q4 = 32,
   localparam int CNT_W    = $clog2(BL_HEIGHT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_req,
   input  logic [ROW_W-1:0] wr_row,
   input  logic             prof_load,
   input  logic [GRP_W-1:0] prof_grp,
   input  logic [CNT_W-1:0] prof_lrs,
   input  logic [CNT_W-1:0] prof_hrs,
   output logic             out_valid,
   output logic [LAT_W-1:0] out_lat,
   output logic [EW_W-1:0]  out_ew
);

   localparam int NGRP = 1 << GRP_W;
   localparam int NQ   = 1 << Q_W;
   localparam int QSH  = $clog2(BL_HEIGHT) - Q_W;
   localparam int unsigned T_LONG = se_pkg::lat_of(0, NQ - 1, NGRP, T_MIN, Q_STEP, G_STEP);

   if ((1 << $clog2(BL_HEIGHT)) != BL_HEIGHT || BL_HEIGHT < NQ) begin : g_bad_height
      $error("BL_HEIGHT must be a power of two no smaller than 2**Q_W");
   end
   if (ROW_W < GRP_W) begin : g_bad_row
      $error("ROW_W must cover the group bits");
   end
   if (T_MIN < 1 || T_LONG >= (1 << LAT_W)) begin : g_bad_lat
      $error("latency table does not fit LAT_W or has a zero entry");
   end

   logic [GRP_W-1:0]              wr_grp;
   logic [CNT_W-1:0]              inc_lrs, inc_hrs;
   logic [NGRP-1:0][CNT_W-1:0]    cnt_lrs, cnt_hrs;
   logic [Q_W-1:0]                ql_d, qh_d;
   logic                          s1_v;
   logic [GRP_W-1:0]              s1_grp;
   logic [Q_W-1:0]                s1_ql, s1_qh;
   logic [LAT_W-1:0]              lat_c;
   logic [EW_W-1:0]               ew_c;

   assign wr_grp = wr_row[ROW_W-1 -: GRP_W];

   se_group_cnt #(.GRP_W(GRP_W), .CNT_W(CNT_W), .BL_HEIGHT(BL_HEIGHT)) cnt_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_req), .wr_grp(wr_grp),
      .ld_en(prof_load), .ld_grp(prof_grp), .ld_lrs(prof_lrs), .ld_hrs(prof_hrs),
      .inc_lrs(inc_lrs), .inc_hrs(inc_hrs),
      .cnt_lrs(cnt_lrs), .cnt_hrs(cnt_hrs)
   );

   se_quant #(.CNT_W(CNT_W), .Q_W(Q_W), .QSH(QSH)) qlrs_i (.cnt(inc_lrs), .q(ql_d));
   se_quant #(.CNT_W(CNT_W), .Q_W(Q_W), .QSH(QSH)) qhrs_i (.cnt(inc_hrs), .q(qh_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_v   <= 1'b0;
         s1_grp <= '0;
         s1_ql  <= '0;
         s1_qh  <= '0;
      end else begin
         s1_v <= wr_req;
         if (wr_req) begin
            s1_grp <= wr_grp;
            s1_ql  <= ql_d;
            s1_qh  <= qh_d;
         end
      end
   end

   se_charge #(
      .GRP_W(GRP_W), .Q_W(Q_W), .LAT_W(LAT_W), .EW_W(EW_W),
      .T_MIN(T_MIN), .Q_STEP(Q_STEP), .G_STEP(G_STEP), .GROWTH_Q4(GROWTH_Q4)
   ) charge_i (
      .grp(s1_grp), .ql(s1_ql), .qh(s1_qh), .lat(lat_c), .ew(ew_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_lat   <= '0;
         out_ew    <= '0;
      end else begin
         out_valid <= s1_v;
         if (s1_v) begin
            out_lat <= lat_c;
            out_ew  <= ew_c;
         end
      end
   end

endmodule

// File: rtl/se_chk.sv
module se_chk #(
   parameter int GRP_W     = 3,
   parameter int CNT_W     = 7,
   parameter int BL_HEIGHT = 64,
   parameter int LAT_W     = 8,
   parameter int EW_W      = 8,
   parameter int ROW_W     = 9,
   parameter int T_MIN     = 16,
   parameter int T_LONG    = 142,
   localparam int NGRP     = 1 << GRP_W
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        wr_req,
   input logic [ROW_W-1:0]            wr_row,
   input logic                        prof_load,
   input logic                        out_valid,
   input logic [LAT_W-1:0]            out_lat,
   input logic [EW_W-1:0]             out_ew,
   input logic [NGRP-1:0][CNT_W-1:0]  cnt_lrs,
   input logic [NGRP-1:0][CNT_W-1:0]  cnt_hrs
);

   logic [1:0]                 cyc;
   logic                       pw, pl;
   logic [GRP_W-1:0]           pg;
   logic [NGRP-1:0][CNT_W-1:0] prev_lrs, prev_hrs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc      <= '0;
         pw       <= 1'b0;
         pl       <= 1'b0;
         pg       <= '0;
         prev_lrs <= '0;
         prev_hrs <= '0;
      end else begin
         if (cyc != 2'd2) cyc <= cyc + 2'd1;
         pw       <= wr_req;
         pl       <= prof_load;
         pg       <= wr_row[ROW_W-1 -: GRP_W];
         prev_lrs <= cnt_lrs;
         prev_hrs <= cnt_hrs;
      end
   end

   function automatic logic all_capped(input logic [NGRP-1:0][CNT_W-1:0] a);
      logic ok;
      ok = 1'b1;
      for (int i = 0; i < NGRP; i++) if (a[i] > CNT_W'(BL_HEIGHT)) ok = 1'b0;
      return ok;
   endfunction

   function automatic logic [CNT_W-1:0] plus1(input logic [CNT_W-1:0] v);
      return (v >= CNT_W'(BL_HEIGHT)) ? CNT_W'(BL_HEIGHT) : v + 1'b1;
   endfunction

   // R9
   strobe_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc == 2'd2) |-> (out_valid == $past(wr_req, 2)));

   // R10
   hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc != 2'd0 && !out_valid) |-> ($stable(out_lat) && $stable(out_ew)));

   // R3
   count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      all_capped(cnt_lrs) && all_capped(cnt_hrs));

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc != 2'd0 && pw && !pl) |->
         (cnt_lrs[pg] == plus1(prev_lrs[pg]) && cnt_hrs[pg] == plus1(prev_hrs[pg])));

   // R5
   lat_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_lat >= LAT_W'(T_MIN) && out_lat <= LAT_W'(T_LONG)));

   // R7
   charge_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_ew != '0));

endmodule

bind stress_est se_chk #(
   .GRP_W(GRP_W), .CNT_W(CNT_W), .BL_HEIGHT(BL_HEIGHT), .LAT_W(LAT_W), .EW_W(EW_W),
   .ROW_W(ROW_W), .T_MIN(T_MIN), .T_LONG(T_LONG)
) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_row(wr_row), .prof_load(prof_load),
   .out_valid(out_valid), .out_lat(out_lat), .out_ew(out_ew),
   .cnt_lrs(cnt_lrs), .cnt_hrs(cnt_hrs)
);

// File: tb/stress_est_tb_top.sv
module stress_est_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_req = 1'b0;
   logic [8:0] wr_row = '0;
   logic       prof_load = 1'b0;
   logic [2:0] prof_grp = '0;
   logic [6:0] prof_lrs = '0;
   logic [6:0] prof_hrs = '0;
   logic       out_valid;
   logic [7:0] out_lat;
   logic [7:0] out_ew;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int m_lrs [8];
   int m_hrs [8];
   bit pend_v = 0;
   int pend_lat = 0, pend_ew = 0;
   bit exp_v = 0;
   int exp_lat = 0, exp_ew = 0;

   always #5 clk = ~clk;

   stress_est dut_i (
      .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_row(wr_row),
      .prof_load(prof_load), .prof_grp(prof_grp), .prof_lrs(prof_lrs), .prof_hrs(prof_hrs),
      .out_valid(out_valid), .out_lat(out_lat), .out_ew(out_ew)
   );

   task automatic chk(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
      end
   endtask

   function automatic int cap(input int v);
      return (v > 64) ? 64 : v;
   endfunction

   function automatic int ratio(input int c);
      return (c / 8 > 7) ? 7 : c / 8;
   endfunction

   // Behavioural reference: one write charged from counts after the increment (R4..R8)
   task automatic price(input int g, input int nl, input int nh, output int lat, output int ew);
      int ql, qh, k, base, scl, v;
      ql   = ratio(nl);
      qh   = ratio(nh);
      lat  = 16 + ql * (4 + 2 * (7 - g));
      base = (142 * 142 + lat * lat - 1) / (lat * lat);
      k    = (ql + qh > 7) ? ql + qh - 7 : 0;
      scl  = 16 << k;
      v    = (base * scl + 15) / 16;
      ew   = (v > 255) ? 255 : v;
   endtask

   // One clock: drive at the falling edge, model at the rising edge, compare at the next falling edge
   task automatic step(input bit w, input int row, input bit ld, input int lg, input int ll, input int lh);
      int g, nl, nh;
      wr_req    = w;
      wr_row    = 9'(row);
      prof_load = ld;
      prof_grp  = 3'(lg);
      prof_lrs  = 7'(ll);
      prof_hrs  = 7'(lh);
      @(posedge clk);
      exp_v = pend_v;
      if (pend_v) begin
         exp_lat = pend_lat;
         exp_ew  = pend_ew;
      end
      pend_v = w;
      if (w) begin
         g  = row / 64;
         nl = cap(m_lrs[g] + 1);
         nh = cap(m_hrs[g] + 1);
         price(g, nl, nh, pend_lat, pend_ew);
         m_lrs[g] = nl;
         m_hrs[g] = nh;
      end
      if (ld) begin
         m_lrs[lg] = cap(ll);
         m_hrs[lg] = cap(lh);
      end
      @(negedge clk);
      chk("R9 strobe", int'(out_valid), int'(exp_v));
      chk(exp_v ? "R5 latency" : "R10 held latency", int'(out_lat), exp_lat);
      chk(exp_v ? "R7 charge" : "R10 held charge", int'(out_ew), exp_ew);
   endtask

   task automatic idle();
      step(0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 8; i++) begin
         m_lrs[i] = 0;
         m_hrs[i] = 0;
      end
      repeat (3) @(negedge clk);
      // R10: reset values
      chk("R10 reset valid", int'(out_valid), 0);
      chk("R10 reset lat", int'(out_lat), 0);
      chk("R10 reset ew", int'(out_ew), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6, R1: group 0 at full conductive ratio costs exactly 1, latency 142
      step(0, 0, 1, 0, 63, 0);
      step(1, 5, 0, 0, 0, 0);
      idle();
      chk("R6 normalised charge", int'(out_ew), 1);
      chk("R1 group0 latency", int'(out_lat), 142);

      // R8: group 7 (row 449), lrs 32 -> q4, hrs 64 -> q7, k=4, t=32, base 20 -> 320 clamps
      step(0, 0, 1, 7, 31, 63);
      step(1, 449, 0, 0, 0, 0);
      idle();
      chk("R8 saturated charge", int'(out_ew), 255);
      chk("R1 group7 latency", int'(out_lat), 32);

      // R4, R7: group 5, counts 40/48 -> q5/q6, k=4, t=56, base 7 -> 112
      step(0, 0, 1, 5, 39, 47);
      step(1, 5 * 64 + 10, 0, 0, 0, 0);
      idle();
      chk("R7 scaled charge", int'(out_ew), 112);
      chk("R4 ratio latency", int'(out_lat), 56);

      // R11: loads alone produce no strobe and keep outputs
      step(0, 0, 1, 3, 10, 10);
      step(0, 0, 1, 6, 20, 20);
      chk("R11 no strobe", int'(out_valid), 0);
      chk("R11 charge held", int'(out_ew), 112);

      // R2: load and write same group same cycle; charge from old+1, store loaded values
      step(0, 0, 1, 4, 0, 0);
      step(1, 4 * 64, 1, 4, 8, 8);
      idle();
      chk("R2 charge from old counts", int'(out_ew), 79);
      step(1, 4 * 64 + 3, 0, 0, 0, 0);
      idle();
      chk("R2 loaded values kept latency", int'(out_lat), 26);
      chk("R2 loaded values kept charge", int'(out_ew), 30);

      // R2: loaded values above bitline height clamp; R3 increments saturate
      step(0, 0, 1, 2, 100, 0);
      step(1, 2 * 64, 0, 0, 0, 0);
      step(1, 2 * 64, 0, 0, 0, 0);
      idle();
      chk("R3 saturated count latency", int'(out_lat), 114);
      chk("R3 charge", int'(out_ew), 2);

      // R9: back-to-back writes across groups
      for (int i = 0; i < 16; i++) step(1, i * 32, 0, 0, 0, 0);
      idle();
      idle();

      // Mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         bit w, ld;
         w  = ($urandom % 4) != 0;
         ld = ($urandom % 16) == 0;
         step(w, int'($urandom % 512), ld, int'($urandom % 8),
              int'($urandom % 72), int'($urandom % 72));
      end
      idle();
      idle();

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule